// File: doc/BRIEF.md
# Firmware Anti-Rollback Gate

This block decides whether a candidate firmware image is allowed to replace the image currently installed on a core. It looks at two 32-bit packed version words, the candidate's and the installed one, and at the core's security counter. That counter sits in write-once bits as a thermometer code: security level N is held as the N lowest bits set to one. The block decodes the stored pattern and checks that the pattern is well formed. It then compares the versions and returns a registered accept or reject verdict together with a reason code.

After an accepted image has been loaded successfully, the surrounding boot logic pulses a load-complete input. If the core's anti-rollback fuse is set, the block then issues a single write strobe to the one-time-programmable array. The data it writes raises the counter to the candidate's security level. A write can only add set bits. The counter width is a parameter. One core uses a 128-bit counter and the other uses a 64-bit counter.

Top module: `rollback_guard`

## Requirements
- R1: A version word carries the build number in bits 7:0, the security level in bits 15:8, the minor version in bits 23:16 and the major version in bits 31:24. When every rule below passes, the block reports accept=1, reject=0 and verdict 0.
- R2: If the candidate word, taken as an unsigned 32-bit number, is not strictly greater than the installed word, the candidate is rejected with verdict 1. Equal words are also rejected.
- R3: If the candidate's security level is below the number of set bits in the stored counter, the candidate is rejected with verdict 2. A candidate whose security level equals the stored count passes this rule.
- R4: If the candidate's security level is greater than CTR_W, the candidate is rejected with verdict 3.
- R5: If the stored counter pattern has a set bit above a clear bit, the pattern is corrupt and the candidate is rejected with verdict 4.
- R6: When more than one rule fails, the reported verdict follows this priority: 4 first, then 3, then 2, then 1.
- R7: Reset clears done, accept, reject, verdict and the write strobe. A request sampled on a clock edge gives a one-cycle done pulse and a verdict in the next cycle. Accept and reject never both read 1, and both hold their value until the next request.
- R8: A load-complete pulse that arrives while an acceptance is pending and the fuse is set raises otp_we for exactly one cycle, one cycle later. Together with the strobe, otp_wd equals the current stored pattern ORed with a pattern of N ones in the low bits, where N is the accepted security level.
- R9: No write happens when the fuse is clear, when the last verdict was a reject, or for a second load-complete pulse after the same acceptance.
- R10: The written pattern never clears a bit that was set in the stored pattern.
- R11: CTR_W selects the counter width. A 64-bit instance accepts security level 64 and rejects 65. A 128-bit instance accepts 128 and rejects 129.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| check_req | input | 1 | One-cycle request to evaluate the candidate |
| cand_ver | input | 32 | Packed version word of the candidate image |
| inst_ver | input | 32 | Packed version word of the installed image |
| otp_q | input | CTR_W | Current contents of the security counter bits |
| rollback_fuse | input | 1 | Anti-rollback enable fuse for this core |
| load_ok | input | 1 | Pulse: the accepted image has loaded successfully |
| done | output | 1 | One-cycle pulse when a verdict becomes valid |
| accept | output | 1 | Last verdict allows the update |
| reject | output | 1 | Last verdict refuses the update; the installed image stays |
| verdict | output | 3 | Reason code: 0 ok, 1 stale, 2 security too low, 3 out of range, 4 corrupt counter |
| otp_we | output | 1 | One-cycle write strobe to the counter bits |
| otp_wd | output | CTR_W | Pattern to program, valid with otp_we |

## Verification
The bench targets the boundaries of each comparison. It uses equal version words, a security level equal to the stored count, and levels of 64/65 and 128/129 on the two widths. A design that compared with greater-or-equal, or that used an off-by-one range limit, would accept an image it must refuse, or refuse one it must accept. Corrupt counter patterns are combined with other failing rules so that the priority of the reason codes is exercised. The commit path is driven with the fuse clear, after a reject, and twice after one acceptance. A design that ignored the fuse or the pending state would burn extra counter bits, and the written pattern is checked against the old contents ORed with the new thermometer.

// File: rtl/rbk_pkg.sv
// Shared types for the anti-rollback gate.
// Assumes version words are 32 bits with fixed byte fields.
package rbk_pkg;

    typedef struct packed {
        logic [7:0] major;
        logic [7:0] minor;
        logic [7:0] secver;
        logic [7:0] build;
    } fw_ver_t;

    typedef enum logic [2:0] {
        VERDICT_OK        = 3'd0,
        VERDICT_STALE     = 3'd1,
        VERDICT_SEC_LOW   = 3'd2,
        VERDICT_SEC_RANGE = 3'd3,
        VERDICT_OTP_BAD   = 3'd4
    } verdict_e;

endpackage

// File: rtl/therm_decode.sv
// Decodes a thermometer-coded counter: counts the set bits and flags a
// pattern that has a set bit above a clear bit.
// Assumes W >= 2.
module therm_decode #(
    parameter int W  = 128,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  pattern,
    output logic [CW-1:0] level,
    output logic          bad
);
    logic [W-2:0] gap;

    // Population count of the stored pattern.
    always_comb begin
        level = '0;
        for (int i = 0; i < W; i++) begin
            level = level + CW'(pattern[i]);
        end
    end

    // A gap exists where bit i+1 is set but bit i is clear.
    for (genvar g = 0; g < W - 1; g++) begin : g_gap
        assign gap[g] = pattern[g+1] & ~pattern[g];
    end

    // Any gap marks the pattern as corrupt.
    assign bad = |gap;

endmodule

// File: rtl/therm_encode.sv
// Builds a thermometer pattern with the lowest `level` bits set.
// Assumes level is an 8-bit count; values above W saturate to all ones.
module therm_encode #(
    parameter int W = 128
) (
    input  logic [7:0]   level,
    output logic [W-1:0] pattern
);
    // Bit i is set when the level exceeds i.
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign pattern[g] = (32'(level) > 32'(g));
    end

endmodule

// File: rtl/verdict_logic.sv
// Combinational decision: applies the corrupt, range, security-floor and
// freshness rules to a candidate and picks the highest-priority reason.
// Assumes otp_level and otp_bad come from a therm_decode of the same width.
module verdict_logic
    import rbk_pkg::*;
#(
    parameter int W  = 128,
    localparam int CW = $clog2(W + 1)
) (
    input  fw_ver_t        cand,
    input  fw_ver_t        inst,
    input  logic [CW-1:0]  otp_level,
    input  logic           otp_bad,
    output verdict_e       verdict
);
    logic newer;
    logic sec_low;
    logic sec_range;

    // Individual rule results.
    always_comb begin
        newer     = (32'(cand) > 32'(inst));
        sec_low   = (32'(cand.secver) < 32'(otp_level));
        sec_range = (32'(cand.secver) > 32'(W));
    end

    // Priority encoding of the failing rules.
    always_comb begin
        if (otp_bad)        verdict = VERDICT_OTP_BAD;
        else if (sec_range) verdict = VERDICT_SEC_RANGE;
        else if (sec_low)   verdict = VERDICT_SEC_LOW;
        else if (!newer)    verdict = VERDICT_STALE;
        else                verdict = VERDICT_OK;
    end

endmodule

// File: rtl/rollback_guard.sv
// Anti-rollback gate for one core. Registers a verdict one cycle after
// check_req. It keeps an acceptance pending until load_ok arrives, then
// issues a single set-only write that raises the thermometer counter.
// Assumes check_req and load_ok are not asserted in the same cycle and that
// otp_q reflects the array contents (updated after each otp_we).
module rollback_guard
    import rbk_pkg::*;
#(
    parameter int CTR_W = 128,
    localparam int CW = $clog2(CTR_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             check_req,
    input  logic [31:0]      cand_ver,
    input  logic [31:0]      inst_ver,
    input  logic [CTR_W-1:0] otp_q,
    input  logic             rollback_fuse,
    input  logic             load_ok,
    output logic             done,
    output logic             accept,
    output logic             reject,
    output logic [2:0]       verdict,
    output logic             otp_we,
    output logic [CTR_W-1:0] otp_wd
);
    logic [CW-1:0]    otp_level;
    logic             otp_bad;
    verdict_e         verdict_c;
    logic             pending;
    logic [7:0]       commit_level;
    logic [CTR_W-1:0] commit_pat;
    fw_ver_t          cand_s;
    fw_ver_t          inst_s;

    assign cand_s = fw_ver_t'(cand_ver);
    assign inst_s = fw_ver_t'(inst_ver);

    therm_decode #(.W(CTR_W)) u_decode (
        .pattern (otp_q),
        .level   (otp_level),
        .bad     (otp_bad)
    );

    verdict_logic #(.W(CTR_W)) u_verdict (
        .cand      (cand_s),
        .inst      (inst_s),
        .otp_level (otp_level),
        .otp_bad   (otp_bad),
        .verdict   (verdict_c)
    );

    therm_encode #(.W(CTR_W)) u_encode (
        .level   (commit_level),
        .pattern (commit_pat)
    );

    // Registers the verdict and tracks whether an acceptance awaits commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done         <= 1'b0;
            accept       <= 1'b0;
            reject       <= 1'b0;
            verdict      <= 3'd0;
            pending      <= 1'b0;
            commit_level <= 8'd0;
        end else begin
            done <= check_req;
            if (check_req) begin
                accept       <= (verdict_c == VERDICT_OK);
                reject       <= (verdict_c != VERDICT_OK);
                verdict      <= verdict_c;
                pending      <= (verdict_c == VERDICT_OK);
                commit_level <= cand_s.secver;
            end else if (load_ok) begin
                pending <= 1'b0;
            end
        end
    end

    // Issues one set-only write per acceptance when the fuse allows it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            otp_we <= 1'b0;
            otp_wd <= '0;
        end else begin
            otp_we <= load_ok && pending && rollback_fuse && !check_req;
            if (load_ok && pending && rollback_fuse && !check_req) begin
                otp_wd <= otp_q | commit_pat;
            end
        end
    end

    // R7: the two verdict flags are mutually exclusive.
    p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && reject));

    // R7: a request is always answered by done in the next cycle.
    p_done_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        check_req |=> done);

    // R5: a corrupt counter forces a reject with the corrupt reason.
    p_corrupt_rejects_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (check_req && otp_bad) |=> (reject && verdict == 3'd4));

    // R9: a write only follows load completion with the fuse set.
    p_fuse_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        otp_we |-> ($past(rollback_fuse) && $past(load_ok)));

    // R10: the written pattern keeps every bit that was already set.
    p_sets_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        otp_we |-> ((otp_wd & $past(otp_q)) == $past(otp_q)));

endmodule

// File: tb/rollback_guard_tb.sv
module rollback_guard_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         check_req = 1'b0;
    logic [31:0]  cand_ver = '0;
    logic [31:0]  inst_ver = '0;
    logic         rollback_fuse = 1'b0;
    logic         load_ok = 1'b0;
    logic [127:0] otp128 = '0;
    logic [63:0]  otp64 = '0;

    logic         done_a, acc_a, rej_a, we_a;
    logic [2:0]   vd_a;
    logic [127:0] wd_a;
    logic         done_b, acc_b, rej_b, we_b;
    logic [2:0]   vd_b;
    logic [63:0]  wd_b;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rollback_guard #(.CTR_W(128)) u_dut (
        .clk(clk), .rst_n(rst_n), .check_req(check_req), .cand_ver(cand_ver),
        .inst_ver(inst_ver), .otp_q(otp128), .rollback_fuse(rollback_fuse),
        .load_ok(load_ok), .done(done_a), .accept(acc_a), .reject(rej_a),
        .verdict(vd_a), .otp_we(we_a), .otp_wd(wd_a)
    );

    rollback_guard #(.CTR_W(64)) u_dut64 (
        .clk(clk), .rst_n(rst_n), .check_req(check_req), .cand_ver(cand_ver),
        .inst_ver(inst_ver), .otp_q(otp64), .rollback_fuse(rollback_fuse),
        .load_ok(load_ok), .done(done_b), .accept(acc_b), .reject(rej_b),
        .verdict(vd_b), .otp_we(we_b), .otp_wd(wd_b)
    );

    // Write-once array model: writes can only OR bits in.
    always @(posedge clk) begin
        if (we_a) otp128 <= otp128 | wd_a;
        if (we_b) otp64  <= otp64 | wd_b;
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_check(input logic [31:0] c, input logic [31:0] i);
        @(negedge clk);
        cand_ver  = c;
        inst_ver  = i;
        check_req = 1'b1;
        @(negedge clk);
        check_req = 1'b0;
    endtask

    task automatic load_pulse();
        @(negedge clk);
        load_ok = 1'b1;
        @(negedge clk);
        load_ok = 1'b0;
    endtask

    task automatic t_reset();
        chk("R7 reset done", 128'(done_a), 0);
        chk("R7 reset accept", 128'(acc_a), 0);
        chk("R7 reset reject", 128'(rej_a), 0);
        chk("R7 reset verdict", 128'(vd_a), 0);
        chk("R7 reset otp_we", 128'(we_a), 0);
    endtask

    task automatic t_accept_commit();
        @(negedge clk);
        otp128 <= 128'h1;
        otp64  <= 64'h1;
        rollback_fuse = 1'b1;
        run_check(32'h01010200, 32'h01000100);
        chk("R1 accept", 128'(acc_a), 1);
        chk("R1 reject low", 128'(rej_a), 0);
        chk("R1 verdict ok", 128'(vd_a), 0);
        chk("R7 done pulse", 128'(done_a), 1);
        chk("R11 accept 64", 128'(acc_b), 1);
        @(negedge clk);
        chk("R7 done drops", 128'(done_a), 0);
        chk("R7 accept held", 128'(acc_a), 1);
        load_pulse();
        chk("R8 we", 128'(we_a), 1);
        chk("R8 wd", wd_a, 128'h3);
        chk("R8 wd 64", 128'(wd_b), 128'h3);
        @(negedge clk);
        chk("R8 we one cycle", 128'(we_a), 0);
        chk("R8 otp updated", otp128, 128'h3);
        load_pulse();
        chk("R9 second load no write", 128'(we_a), 0);
    endtask

    task automatic t_stale();
        run_check(32'h02000300, 32'h02000300);
        chk("R2 equal rejected", 128'(rej_a), 1);
        chk("R2 equal verdict", 128'(vd_a), 1);
        run_check(32'h01000300, 32'h02000300);
        chk("R2 older verdict", 128'(vd_a), 1);
        load_pulse();
        chk("R9 no write after reject", 128'(we_a), 0);
    endtask

    task automatic t_sec_floor();
        run_check(32'h03000100, 32'h02000000);
        chk("R3 below count", 128'(vd_a), 2);
        chk("R3 below count reject", 128'(rej_a), 1);
        run_check(32'h03000200, 32'h02000000);
        chk("R3 equal count accepted", 128'(acc_a), 1);
    endtask

    task automatic t_range();
        run_check(32'h03008100, 32'h02000000);
        chk("R4 129 on 128", 128'(vd_a), 3);
        run_check(32'h03008000, 32'h02000000);
        chk("R11 128 on 128", 128'(acc_a), 1);
        chk("R4 128 on 64", 128'(vd_b), 3);
        run_check(32'h03004100, 32'h02000000);
        chk("R4 65 on 64", 128'(vd_b), 3);
        chk("R11 65 on 128", 128'(acc_a), 1);
        run_check(32'h03004000, 32'h02000000);
        chk("R11 64 on 64", 128'(acc_b), 1);
        load_pulse();
        chk("R8 wd 64 ones", wd_a, {64'h0, {64{1'b1}}});
        chk("R11 wd 64 full", 128'(wd_b), 128'(64'hFFFFFFFFFFFFFFFF));
        run_check(32'h04008000, 32'h03004000);
        chk("R11 128 accept", 128'(acc_a), 1);
        load_pulse();
        chk("R8 wd all ones", wd_a, {128{1'b1}});
        chk("R9 64 rejected no write", 128'(we_b), 0);
        @(negedge clk);
        chk("R10 otp all set", otp128, {128{1'b1}});
    endtask

    task automatic t_fuse_off();
        rollback_fuse = 1'b0;
        run_check(32'h05008000, 32'h04008000);
        chk("R1 accept full count", 128'(acc_a), 1);
        load_pulse();
        chk("R9 fuse clear no write", 128'(we_a), 0);
    endtask

    task automatic t_corrupt_priority();
        @(negedge clk);
        otp128 <= 128'h5;
        run_check(32'h06000300, 32'h00000000);
        chk("R5 corrupt verdict", 128'(vd_a), 4);
        chk("R5 corrupt reject", 128'(rej_a), 1);
        run_check(32'h00000300, 32'h06000000);
        chk("R6 corrupt over stale", 128'(vd_a), 4);
        @(negedge clk);
        otp128 <= 128'h3;
        run_check(32'h00009000, 32'h06000000);
        chk("R6 range over stale", 128'(vd_a), 3);
        run_check(32'h00000100, 32'h06000000);
        chk("R6 low over stale", 128'(vd_a), 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_accept_commit();
        t_stale();
        t_sec_floor();
        t_range();
        t_fuse_off();
        t_corrupt_priority();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule